// File: doc/BRIEF.md
# Raster timing generator

This block produces the raster timing for an active-matrix display panel: a divided pixel clock, horizontal sync, vertical sync, an output-enable (data-valid) strobe, and a one-cycle pixel request that a pixel data path uses to present the next pixel. All timing comes from three configuration words written through a simple select/write-enable port. Line geometry covers the sync width, a lead-in wait, the active pixels and a trailing wait. Frame geometry uses the same four segments, counted in lines.

A level `run` input starts the raster from idle at the first line of a frame. When `run` is dropped, the current frame is allowed to finish, and the block returns to idle at the frame boundary. Start-of-frame, end-of-frame and stop-complete events appear as one-core-clock pulses. Each event also feeds a combined interrupt line through its own mask bit.

While idle, the timing shadow follows the configuration words. While running, the shadow is reloaded only when one frame rolls over into the next. A frame is therefore always drawn with a single consistent geometry.

Top module: `raster_tgen`

## Requirements
- R1: After synchronous reset all configuration words are zero, the block is idle, `hsync`, `vsync`, `oe`, `pix_req`, `sof`, `eof`, `done` and `irq` are 0, and `pclk` is 1.
- R2: While running, `pclk` has a period of 2×(D+1) core clocks, where D is the divisor in mode word bits [7:0]. It is high and low for D+1 core clocks each, so D=0 toggles it on every core clock.
- R3: Each line starts with hsync for S+1 pixel periods, then a lead wait of B+1, then A+1 active pixels, then a trailing wait of E+1. The timing word (select 0) holds A in [9:0], S in [15:10], B in [23:16] and E in [31:24].
- R4: Each frame starts with vsync for VS+1 lines, then VB lines of lead wait, then L+1 active lines, then VE lines of trailing wait. A wait of zero inserts no lines. The vertical word (select 1) holds L in [9:0], VS in [15:10], VB in [23:16] and VE in [31:24].
- R5: `oe` is asserted only when the pixel position is inside the active pixels of an active line.
- R6: The mode word (select 2) has three polarity bits: bit 8 inverts vsync, bit 9 inverts hsync and bit 10 inverts oe, each making its output active low. When a bit is clear, its output is active high.
- R7: With mode bit 11 clear, pixel positions change on the rising edge of `pclk`. With bit 11 set, they change on the falling edge.
- R8: `pix_req` pulses for exactly the first core clock of every active pixel period.
- R9: When `run` is seen high in idle, the raster begins at line 0 pixel 0 on the next core clock, and `sof` pulses in that same cycle.
- R10: When the last pixel period of a frame ends, `eof` pulses. If `run` is still high, the next frame begins immediately and `sof` pulses in the same cycle.
- R11: If `run` is low when a frame ends, the block returns to idle, and `done` pulses together with `eof`. Dropping `run` earlier does not shorten the frame.
- R12: Configuration writes made while running take effect only from the next frame. Writes made while idle take effect at the next start.
- R13: `irq` is high in any cycle in which an event pulses and its mask bit is clear. The mask bits are mode word bit 12 (sof), bit 13 (eof) and bit 14 (done), and they act immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 line timing, 1 frame timing, 2 mode |
| cfg_wdata | input | 32 | Configuration write data |
| run | input | 1 | Level request to draw frames |
| pclk | output | 1 | Pixel clock |
| hsync | output | 1 | Horizontal sync, polarity selectable |
| vsync | output | 1 | Vertical sync, polarity selectable |
| oe | output | 1 | Output enable (data valid), polarity selectable |
| pix_req | output | 1 | One-cycle pulse at the start of each active pixel period |
| sof | output | 1 | Start-of-frame pulse |
| eof | output | 1 | End-of-frame pulse |
| done | output | 1 | Stop-complete pulse |
| irq | output | 1 | OR of unmasked event pulses |

## Verification
A wrong position count or divider phase shows up at the ports within one pixel period. It appears as an hsync or oe edge one period early or late against a reference that tracks a single linear pixel index, or as a `pclk` level that disagrees. A shadow that reloads at the wrong time shifts the line length of the current frame, and the first mismatching hsync edge reveals it, no more than one line later. Mistakes in the stop logic show as `done` missing at the frame end, or as the raster continuing after it. Every output is compared on every core clock, so a mismatch is reported in the cycle it first appears.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CFG_W  = 32;
    localparam int SEL_W  = 2;
    localparam int NREG   = 3;
    localparam int PIX_W  = 10;
    localparam int SYNC_W = 6;
    localparam int WAIT_W = 8;
    localparam int DIV_W  = 8;
    localparam int POS_W  = 11;

    // line timing word, every field holds count-1
    typedef struct packed {
        logic [WAIT_W-1:0] tail_m1;
        logic [WAIT_W-1:0] lead_m1;
        logic [SYNC_W-1:0] sync_m1;
        logic [PIX_W-1:0]  pix_m1;
    } htime_t;

    // frame timing word, waits hold the raw line count
    typedef struct packed {
        logic [WAIT_W-1:0] tail;
        logic [WAIT_W-1:0] lead;
        logic [SYNC_W-1:0] sync_m1;
        logic [PIX_W-1:0]  lines_m1;
    } vtime_t;

    typedef struct packed {
        logic pclk_fall;
        logic oe_low;
        logic hs_low;
        logic vs_low;
        logic [DIV_W-1:0] div;
    } pix_mode_t;

    typedef struct packed {
        logic done_m;
        logic eof_m;
        logic sof_m;
    } mask_t;

    typedef struct packed {
        mask_t     mask;
        pix_mode_t pm;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic [POS_W-1:0] sync;
        logic [POS_W-1:0] lead;
        logic [POS_W-1:0] act;
        logic [POS_W-1:0] tail;
    } span_t;

    typedef struct packed {
        logic sof;
        logic eof;
        logic done;
    } evt_t;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_t;

    function automatic span_t h_span(input htime_t t);
        span_t s;
        s.sync = POS_W'(t.sync_m1) + POS_W'(1);
        s.lead = POS_W'(t.lead_m1) + POS_W'(1);
        s.act  = POS_W'(t.pix_m1)  + POS_W'(1);
        s.tail = POS_W'(t.tail_m1) + POS_W'(1);
        return s;
    endfunction

    function automatic span_t v_span(input vtime_t t);
        span_t s;
        s.sync = POS_W'(t.sync_m1)  + POS_W'(1);
        s.lead = POS_W'(t.lead);
        s.act  = POS_W'(t.lines_m1) + POS_W'(1);
        s.tail = POS_W'(t.tail);
        return s;
    endfunction

endpackage

// File: rtl/raster_cfg.sv
module raster_cfg
    import raster_pkg::*;
#(
    parameter int DW = CFG_W,
    parameter int SW = SEL_W,
    parameter int NR = NREG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output htime_t        sh_ht,
    output vtime_t        sh_vt,
    output pix_mode_t     sh_pm,
    output mask_t         live_mask
);

    logic [NR-1:0] hit;
    htime_t ht_q;
    vtime_t vt_q;
    mode_t  md_q;

    for (genvar g = 0; g < NR; g++) begin : g_dec
        assign hit[g] = we && (sel == SW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ht_q <= '0;
            vt_q <= '0;
            md_q <= '0;
        end else begin
            if (hit[0]) ht_q <= htime_t'(wdata);
            if (hit[1]) vt_q <= vtime_t'(wdata);
            if (hit[2]) md_q <= mode_t'(wdata[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_ht <= '0;
            sh_vt <= '0;
            sh_pm <= '0;
        end else if (load) begin
            sh_ht <= ht_q;
            sh_vt <= vt_q;
            sh_pm <= md_q.pm;
        end
    end

    assign live_mask = md_q.mask;

endmodule

// File: rtl/raster_pclk.sv
module raster_pclk
    import raster_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          phase,
    output logic          adv,
    output logic          first
);

    logic [DW-1:0] dcnt;
    logic          half_end;

    assign half_end = (dcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dcnt  <= '0;
            phase <= 1'b0;
        end else if (half_end) begin
            dcnt  <= '0;
            phase <= ~phase;
        end else begin
            dcnt  <= dcnt + DW'(1);
        end
    end

    assign adv   = en && phase && half_end;
    assign first = en && !phase && (dcnt == '0);

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !half_end) |=> $stable(phase)); // R2

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (en && half_end) |=> (phase != $past(phase))); // R2

endmodule

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
#(
    parameter int W = POS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_lead,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_tail,
    output logic [W-1:0] pos,
    output logic         at_end,
    output logic         in_sync,
    output logic         in_act
);

    logic [W-1:0] total;
    logic [W-1:0] act_lo;
    logic [W-1:0] act_hi;

    assign total  = len_sync + len_lead + len_act + len_tail;
    assign act_lo = len_sync + len_lead;
    assign act_hi = act_lo + len_act;
    assign at_end = (pos == total - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos <= '0;
        end else if (step) begin
            pos <= at_end ? '0 : pos + W'(1);
        end
    end

    assign in_sync = (pos < len_sync);
    assign in_act  = (pos >= act_lo) && (pos < act_hi);

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pos < total); // R3

endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             run,
    output logic             pclk,
    output logic             hsync,
    output logic             vsync,
    output logic             oe,
    output logic             pix_req,
    output logic             sof,
    output logic             eof,
    output logic             done,
    output logic             irq
);

    run_state_t st;
    htime_t     sh_ht;
    vtime_t     sh_vt;
    pix_mode_t  sh_pm;
    mask_t      live_mask;
    span_t      hsp;
    span_t      vsp;
    evt_t       evt_q;

    logic running, start, frame_end, load;
    logic phase, adv, first;
    logic [POS_W-1:0] h_pos, v_pos;
    logic h_end, v_end, h_sync, v_sync, h_act, v_act;
    logic hs_act, vs_act, de_act;

    assign running   = (st == ST_RUN);
    assign start     = !running && run;
    assign frame_end = adv && h_end && v_end;
    assign load      = !running || (frame_end && run);
    assign hsp       = h_span(sh_ht);
    assign vsp       = v_span(sh_vt);

    raster_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .load     (load),
        .sh_ht    (sh_ht),
        .sh_vt    (sh_vt),
        .sh_pm    (sh_pm),
        .live_mask(live_mask)
    );

    raster_pclk u_pclk (
        .clk  (clk),
        .rst  (rst),
        .en   (running),
        .div  (sh_pm.div),
        .phase(phase),
        .adv  (adv),
        .first(first)
    );

    raster_axis u_hax (
        .clk     (clk),
        .rst     (rst),
        .clr     (!running),
        .step    (adv),
        .len_sync(hsp.sync),
        .len_lead(hsp.lead),
        .len_act (hsp.act),
        .len_tail(hsp.tail),
        .pos     (h_pos),
        .at_end  (h_end),
        .in_sync (h_sync),
        .in_act  (h_act)
    );

    raster_axis u_vax (
        .clk     (clk),
        .rst     (rst),
        .clr     (!running),
        .step    (adv && h_end),
        .len_sync(vsp.sync),
        .len_lead(vsp.lead),
        .len_act (vsp.act),
        .len_tail(vsp.tail),
        .pos     (v_pos),
        .at_end  (v_end),
        .in_sync (v_sync),
        .in_act  (v_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (run) st <= ST_RUN;
                ST_RUN:  if (frame_end && !run) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.sof  <= start || (frame_end && run);
            evt_q.eof  <= frame_end;
            evt_q.done <= frame_end && !run;
        end
    end

    assign hs_act = running && h_sync;
    assign vs_act = running && v_sync;
    assign de_act = running && h_act && v_act;

    assign hsync   = hs_act ^ sh_pm.hs_low;
    assign vsync   = vs_act ^ sh_pm.vs_low;
    assign oe      = de_act ^ sh_pm.oe_low;
    assign pclk    = sh_pm.pclk_fall ? phase : !phase;
    assign pix_req = de_act && first;
    assign sof     = evt_q.sof;
    assign eof     = evt_q.eof;
    assign done    = evt_q.done;
    assign irq     = (evt_q.sof  && !live_mask.sof_m) ||
                     (evt_q.eof  && !live_mask.eof_m) ||
                     (evt_q.done && !live_mask.done_m);

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (running && !frame_end) |=> ($stable(sh_ht) && $stable(sh_vt) && $stable(sh_pm))); // R12

    AST_SOF_AT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        evt_q.sof |-> (running && h_pos == '0 && v_pos == '0)); // R9

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        evt_q.done |-> (!running && evt_q.eof)); // R11

    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (rst)
        de_act |-> (!hs_act && !vs_act)); // R5

endmodule

// File: tb/sim_raster_tgen.sv
module sim_raster_tgen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        run = 1'b0;
    logic pclk, hsync, vsync, oe, pix_req, sof, eof, done, irq;

    int vectors = 0;
    int miscmp  = 0;
    bit cmp_en  = 1'b0;
    bit r1_win  = 1'b1;

    always #10 clk = ~clk;

    raster_tgen u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .run(run), .pclk(pclk), .hsync(hsync),
        .vsync(vsync), .oe(oe), .pix_req(pix_req), .sof(sof), .eof(eof),
        .done(done), .irq(irq)
    );

    // reference model: one linear pixel index per frame and a core-cycle count per pixel
    logic [31:0] m_lh, m_lv, m_lm, m_sh, m_sv, m_sm;
    bit m_run, m_sof, m_eof, m_dd;
    int m_cyc, m_idx, m_period, m_flen;
    bit n_sof, n_eof, n_dd;

    function automatic int line_len(input logic [31:0] w);
        return (int'(w[15:10]) + 1) + (int'(w[23:16]) + 1) + (int'(w[9:0]) + 1) + (int'(w[31:24]) + 1);
    endfunction

    function automatic int frame_lines(input logic [31:0] w);
        return (int'(w[15:10]) + 1) + int'(w[23:16]) + (int'(w[9:0]) + 1) + int'(w[31:24]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lh = 0; m_lv = 0; m_lm = 0; m_sh = 0; m_sv = 0; m_sm = 0;
            m_run = 0; m_cyc = 0; m_idx = 0; m_sof = 0; m_eof = 0; m_dd = 0;
        end else begin
            m_period = 2 * (int'(m_sm[7:0]) + 1);
            m_flen   = line_len(m_sh) * frame_lines(m_sv);
            n_sof = 0; n_eof = 0; n_dd = 0;
            if (!m_run) begin
                m_sh = m_lh; m_sv = m_lv; m_sm = m_lm;
                if (run) begin
                    m_run = 1; n_sof = 1; m_cyc = 0; m_idx = 0;
                end
            end else begin
                m_cyc++;
                if (m_cyc == m_period) begin
                    m_cyc = 0;
                    m_idx++;
                    if (m_idx == m_flen) begin
                        m_idx = 0;
                        n_eof = 1;
                        if (!run) begin
                            m_run = 0; n_dd = 1;
                        end else begin
                            m_sh = m_lh; m_sv = m_lv; m_sm = m_lm; n_sof = 1;
                        end
                    end
                end
            end
            m_sof = n_sof; m_eof = n_eof; m_dd = n_dd;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_lh = cfg_wdata;
                    2'd1: m_lv = cfg_wdata;
                    2'd2: m_lm = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s at %0t actual=%b expected=%b", r1_win ? "R1" : tag, nm, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            int ht, h, v, hsw, blw, npx, vsw, bfw, nln;
            bit ph, e_hs, e_vs, e_de, e_irq;
            ht  = line_len(m_sh);
            h   = m_idx % ht;
            v   = m_idx / ht;
            hsw = int'(m_sh[15:10]) + 1; blw = int'(m_sh[23:16]) + 1; npx = int'(m_sh[9:0]) + 1;
            vsw = int'(m_sv[15:10]) + 1; bfw = int'(m_sv[23:16]);     nln = int'(m_sv[9:0]) + 1;
            ph   = m_run && (m_cyc >= int'(m_sm[7:0]) + 1);
            e_hs = m_run && (h < hsw);
            e_vs = m_run && (v < vsw);
            e_de = m_run && (h >= hsw + blw) && (h < hsw + blw + npx) &&
                   (v >= vsw + bfw) && (v < vsw + bfw + nln);
            e_irq = (m_sof && !m_lm[12]) || (m_eof && !m_lm[13]) || (m_dd && !m_lm[14]);
            vectors++;
            chk("R2_R7", "pclk",    pclk,    m_sm[11] ? ph : !ph);
            chk("R3_R6", "hsync",   hsync,   e_hs ^ m_sm[9]);
            chk("R4_R6", "vsync",   vsync,   e_vs ^ m_sm[8]);
            chk("R5_R6", "oe",      oe,      e_de ^ m_sm[10]);
            chk("R8",    "pix_req", pix_req, e_de && (m_cyc == 0));
            chk("R9",    "sof",     sof,     m_sof);
            chk("R10",   "eof",     eof,     m_eof);
            chk("R11",   "done",    done,    m_dd);
            chk("R13",   "irq",     irq,     e_irq);
        end
    end

    // R14-free map: select 0 line word, 1 frame word, 2 mode word (see R3, R4, R6, R13)
    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog expired at %0t actual=running expected=finished", $time);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        @(negedge clk);
        cmp_en = 1'b1;              // R1 reset state compared from here
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        r1_win = 1'b0;
        // R3 R4: 8-pixel lines, 5-line frames, no trailing frame wait
        wr(2'd0, {8'd0, 8'd1, 6'd0, 10'd3});
        wr(2'd1, {8'd0, 8'd1, 6'd0, 10'd2});
        wr(2'd2, 32'h0000_0000);    // R2: divisor 0
        repeat (4) @(negedge clk);
        run = 1'b1;                 // R9
        repeat (200) @(negedge clk);
        // R12: mid-frame writes wait for the frame boundary
        wr(2'd0, {8'd2, 8'd0, 6'd1, 10'd5});
        wr(2'd2, 32'h0000_0D01);    // R6 R7: vs/oe low, falling edge, divisor 1
        repeat (400) @(negedge clk);
        wr(2'd2, 32'h0000_5D01);    // R13: sof and done masked
        repeat (300) @(negedge clk);
        run = 1'b0;                 // R11: stop waits for frame end
        repeat (600) @(negedge clk);
        // idle writes, zero lead wait in frame, nonzero trailing wait
        wr(2'd1, {8'd2, 8'd0, 6'd1, 10'd3});
        wr(2'd2, 32'h0000_2202);    // hs low, eof masked, divisor 2
        repeat (3) @(negedge clk);
        run = 1'b1;
        repeat (1200) @(negedge clk);
        run = 1'b0;
        repeat (1500) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule